// File: doc/BRIEF.md
# Timebase and Decrementer Unit

This unit keeps time for a processor core. It holds a 64-bit timebase that counts up, a 32-bit decrementer that counts down, an optional second decrementer reserved for a hypervisor, and a 64-bit utilisation counter that software can load. Every counter advances by one step in each cycle where the shared `tick` enable is high. Tick generation and exception vectoring are done outside the unit.

Software reaches the counters through a request/response register port. A request carries a write flag, a 3-bit selector and write data. It is accepted in a cycle where `req_valid` and `req_ready` are both high. Writes produce no response. A read loads `rsp_data` with the selected value as it stood before that cycle's update, and raises `rsp_valid`. The response is held until `rsp_ready` takes it. While a response is waiting and `rsp_ready` is low, `req_ready` is low, so back-pressure on the response side stalls new requests.

Each decrementer has a sticky exception request. It rises when the counter is ticked while at zero, and when software writes a negative value over a non-negative one. A control pin selects a coarse real-time-clock view, in which the timebase lower word is masked.

Top module: `tbd_unit`

## Requirements
- R1: After reset, the timebase and the utilisation counter are zero, both decrementers hold 0xFFFFFFFF, and both exception requests are low.
- R2: Each cycle with `tick` high increments the 64-bit timebase and the 64-bit utilisation counter by one, with the carry propagating from the lower word into the upper word.
- R3: A write to one timebase word leaves the other word at its current value. A write takes priority over a tick in the same cycle, so that tick is lost for the written counter only.
- R4: A tick decrements a decrementer by one. A tick while the decrementer holds zero reloads it to 0xFFFFFFFF and raises that decrementer's exception request.
- R5: A write with bit 31 set, made while the decrementer's current bit 31 is clear, raises the exception request in the next cycle. Other writes do not raise the request.
- R6: An exception request stays high until its acknowledge input is high. When a new event coincides with the acknowledge, the request stays high.
- R7: While `rtc_mode` is high, a write to the timebase lower word stores the data ANDed with 0x3FFFFF80, and a read of that word returns the count ANDed with 0x3FFFFF80.
- R8: The hypervisor decrementer follows R4 to R6 with its own value, request (`hdec_irq`) and acknowledge (`hdec_ack`). It is independent of the main decrementer.
- R9: The utilisation counter is loaded word by word with the same keep-the-other-word rule as the timebase, and then counts ticks from the loaded value.
- R10: Selector codes: 0 is the timebase lower word, 1 the timebase upper word, 2 the decrementer, 3 the hypervisor decrementer, 4 the utilisation counter lower word, 5 its upper word. Codes 6 and 7 read as zero and ignore writes.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. A read's `rsp_data` holds the pre-update value and stays stable while `rsp_valid` is high and `rsp_ready` is low. Writes never raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase advance enable |
| rtc_mode | input | 1 | Masked real-time-clock view of the lower word |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register selector (R10) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 32 | Read data |
| dec_irq | output | 1 | Decrementer exception request |
| dec_ack | input | 1 | Clears `dec_irq` |
| hdec_irq | output | 1 | Hypervisor decrementer exception request |
| hdec_ack | input | 1 | Clears `hdec_irq` |

## Verification
Two kinds of same-cycle collision are provoked on purpose.

- A register write is issued in a cycle where `tick` is high. The bench judges it by reading back both words, and by confirming that the other counters still took the tick.
- An acknowledge is driven in the cycle where a decrementer expires. The bench judges it by checking that the exception request stays high afterwards.

A reference model inside the bench steps through every cycle, and read results are compared against a queue of expected values.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [2:0] {
    SEL_TB_LO   = 3'd0,
    SEL_TB_HI   = 3'd1,
    SEL_DEC     = 3'd2,
    SEL_HDEC    = 3'd3,
    SEL_UT_LO   = 3'd4,
    SEL_UT_HI   = 3'd5,
    SEL_RSVD6   = 3'd6,
    SEL_RSVD7   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/tbd_wide_counter.sv
// Up-counter of two words, each word writable on its own.
module tbd_wide_counter #(
  parameter int WORD_W = 32,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] lo_wmask,
  output logic [CNT_W-1:0]  value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wr_lo) begin
      value[WORD_W-1:0] <= wdata & lo_wmask;
    end else if (wr_hi) begin
      value[CNT_W-1:WORD_W] <= wdata;
    end else if (tick) begin
      value <= value + 1'b1;
    end
  end

  AST_TICK_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_lo && !wr_hi) |=> value == $past(value) + 1'b1); // R2
  AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi && !wr_lo |=> value[WORD_W-1:0] == $past(value[WORD_W-1:0])); // R3
  AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> value[CNT_W-1:WORD_W] == $past(value[CNT_W-1:WORD_W])); // R3
endmodule

// File: rtl/tbd_decrementer.sv
// Down-counter with wrap-on-expiry and sticky exception request.
module tbd_decrementer #(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [DEC_W-1:0] wdata,
  input  logic             ack,
  output logic [DEC_W-1:0] value,
  output logic             irq
);
  localparam int SIGN = DEC_W - 1;

  logic at_zero;
  logic neg_over_pos;
  logic expire;
  logic raise;

  assign at_zero      = (value == '0);
  assign neg_over_pos = wr && wdata[SIGN] && !value[SIGN];
  assign expire       = !wr && tick && at_zero;
  assign raise        = neg_over_pos || expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '1;
    end else if (wr) begin
      value <= wdata;
    end else if (tick) begin
      value <= at_zero ? '1 : value - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (raise) begin
      irq <= 1'b1;
    end else if (ack) begin
      irq <= 1'b0;
    end
  end

  AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && value == '0) |=> (value == '1) && irq); // R4
  AST_NEG_WRITE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[SIGN] && !value[SIGN]) |=> irq); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq); // R6
  AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && value != '0) |=> value == $past(value) - 1'b1); // R4
endmodule

// File: rtl/tbd_unit.sv
module tbd_unit
  import tbd_pkg::*;
#(
  parameter int          WORD_W   = 32,
  parameter bit          HYP_EN   = 1'b1,
  parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80,
  localparam int         CNT_W    = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rtc_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_sel,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              dec_irq,
  input  logic              dec_ack,
  output logic              hdec_irq,
  input  logic              hdec_ack
);
  reg_sel_e          sel;
  logic              accept;
  logic              rd_acc;
  logic              wr_acc;
  logic [WORD_W-1:0] lo_mask;
  logic [WORD_W-1:0] rd_mux;
  logic [CNT_W-1:0]  tb_val;
  logic [CNT_W-1:0]  ut_val;
  logic [WORD_W-1:0] dec_val;
  logic [WORD_W-1:0] hdec_val;

  assign sel       = reg_sel_e'(req_sel);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_acc    = accept && !req_write;
  assign wr_acc    = accept && req_write;
  assign lo_mask   = rtc_mode ? RTC_MASK[WORD_W-1:0] : '1;

  tbd_wide_counter #(.WORD_W(WORD_W)) u_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_lo    (wr_acc && sel == SEL_TB_LO),
    .wr_hi    (wr_acc && sel == SEL_TB_HI),
    .wdata    (req_wdata),
    .lo_wmask (lo_mask),
    .value    (tb_val)
  );

  tbd_wide_counter #(.WORD_W(WORD_W)) u_util (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_lo    (wr_acc && sel == SEL_UT_LO),
    .wr_hi    (wr_acc && sel == SEL_UT_HI),
    .wdata    (req_wdata),
    .lo_wmask ('1),
    .value    (ut_val)
  );

  tbd_decrementer #(.DEC_W(WORD_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr    (wr_acc && sel == SEL_DEC),
    .wdata (req_wdata),
    .ack   (dec_ack),
    .value (dec_val),
    .irq   (dec_irq)
  );

  generate
    if (HYP_EN) begin : g_hyp
      tbd_decrementer #(.DEC_W(WORD_W)) u_hdec (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr    (wr_acc && sel == SEL_HDEC),
        .wdata (req_wdata),
        .ack   (hdec_ack),
        .value (hdec_val),
        .irq   (hdec_irq)
      );
    end else begin : g_no_hyp
      logic unused_hdec_ack;
      assign unused_hdec_ack = hdec_ack;
      assign hdec_val = '0;
      assign hdec_irq = 1'b0;
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_TB_LO: rd_mux = tb_val[WORD_W-1:0] & lo_mask;
      SEL_TB_HI: rd_mux = tb_val[CNT_W-1:WORD_W];
      SEL_DEC:   rd_mux = dec_val;
      SEL_HDEC:  rd_mux = hdec_val;
      SEL_UT_LO: rd_mux = ut_val[WORD_W-1:0];
      SEL_UT_HI: rd_mux = ut_val[CNT_W-1:WORD_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data)); // R11
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (!rsp_valid || rsp_ready)) |=> !rsp_valid); // R11
  AST_RTC_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && sel == SEL_TB_LO && rtc_mode) |=> (rsp_data & ~RTC_MASK[WORD_W-1:0]) == '0); // R7
endmodule

// File: tb/test_tbd_unit.sv
module test_tbd_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h3FFF_FF80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        rtc_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_sel = 3'd0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        dec_irq;
  logic        dec_ack = 1'b0;
  logic        hdec_irq;
  logic        hdec_ack = 1'b0;

  tbd_unit i_tbd_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rtc_mode(rtc_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .dec_irq(dec_irq),
    .dec_ack(dec_ack), .hdec_irq(hdec_irq), .hdec_ack(hdec_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  // reference model
  logic [63:0] m_tb = '0;
  logic [63:0] m_ut = '0;
  logic [31:0] m_dec = '1;
  logic [31:0] m_hdec = '1;
  bit          m_dirq = 1'b0;
  bit          m_hirq = 1'b0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [2:0] s);
    case (s)
      3'd0: return m_tb[31:0] & (rtc_mode ? MASK : 32'hFFFF_FFFF);
      3'd1: return m_tb[63:32];
      3'd2: return m_dec;
      3'd3: return m_hdec;
      3'd4: return m_ut[31:0];
      3'd5: return m_ut[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic dec_model(inout logic [31:0] v, inout bit irq, input bit w,
                           input logic [31:0] d, input bit tk, input bit ak);
    bit ev;
    ev = (w && d[31] && !v[31]) || (!w && tk && v == 32'h0);
    if (w) v = d;
    else if (tk) v = (v == 32'h0) ? 32'hFFFF_FFFF : v - 1;
    if (ev) irq = 1'b1;
    else if (ak) irq = 1'b0;
  endtask

  task automatic step(bit tk, bit rv, bit wr, logic [2:0] s, logic [31:0] wd,
                      bit da, bit ha);
    bit acc;
    exp_t e;
    @(negedge clk);
    tick = tk; req_valid = rv; req_write = wr; req_sel = s; req_wdata = wd;
    dec_ack = da; hdec_ack = ha;
    #1;
    acc = rv && req_ready;
    if (acc && !wr) begin
      e.val = model_read(s); e.tag = cur_tag;
      exp_q.push_back(e);
    end
    if (acc && wr && s == 3'd0) m_tb[31:0] = wd & (rtc_mode ? MASK : 32'hFFFF_FFFF);
    else if (acc && wr && s == 3'd1) m_tb[63:32] = wd;
    else if (tk) m_tb = m_tb + 1;
    if (acc && wr && s == 3'd4) m_ut[31:0] = wd;
    else if (acc && wr && s == 3'd5) m_ut[63:32] = wd;
    else if (tk) m_ut = m_ut + 1;
    dec_model(m_dec, m_dirq, acc && wr && s == 3'd2, wd, tk, da);
    dec_model(m_hdec, m_hirq, acc && wr && s == 3'd3, wd, tk, ha);
    @(posedge clk);
    #2;
    check({cur_tag, " dec_irq"}, {63'h0, dec_irq}, {63'h0, m_dirq});
    check({cur_tag, " hdec_irq"}, {63'h0, hdec_irq}, {63'h0, m_hirq});
    tick = 0; req_valid = 0; req_write = 0; dec_ack = 0; hdec_ack = 0;
  endtask

  task automatic rd(logic [2:0] s);
    step(0, 1, 0, s, 32'h0, 0, 0);
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    step(0, 1, 1, s, d, 0, 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 3'd0, 32'h0, 0, 0);
  endtask

  // monitor: compares read responses as they are handed over
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R11: unexpected response actual %h expected none", rsp_data);
        end else begin
          e = exp_q.pop_front();
          check({e.tag, " read"}, {32'h0, rsp_data}, {32'h0, e.val});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 dec_irq at reset", {63'h0, dec_irq}, 64'h0);
    check("R1 hdec_irq at reset", {63'h0, hdec_irq}, 64'h0);
    check("R11 rsp_valid at reset", {63'h0, rsp_valid}, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R10: reset values through every selector code
    cur_tag = "R1";
    for (int s = 0; s < 6; s++) rd(3'(s));
    cur_tag = "R10";
    rd(3'd6); rd(3'd7);
    wr(3'd6, 32'hDEAD_BEEF); wr(3'd7, 32'hDEAD_BEEF);
    for (int s = 0; s < 8; s++) rd(3'(s));

    // R2: counting and carry
    cur_tag = "R2";
    ticks(5);
    rd(3'd0); rd(3'd2); rd(3'd3); rd(3'd4);
    wr(3'd0, 32'hFFFF_FFFE);
    ticks(3);
    rd(3'd0); rd(3'd1);

    // R3: write colliding with a tick; the other word is kept
    cur_tag = "R3";
    step(1, 1, 1, 3'd1, 32'h1234_5678, 0, 0);
    rd(3'd0); rd(3'd1); rd(3'd2); rd(3'd4);
    step(1, 1, 1, 3'd0, 32'h0000_0100, 0, 0);
    rd(3'd0); rd(3'd1);

    // R4 / R6: expiry, sticky request, acknowledge
    cur_tag = "R4";
    wr(3'd2, 32'h2);
    ticks(3);
    rd(3'd2);
    cur_tag = "R6";
    ticks(2);
    step(0, 0, 0, 3'd0, 32'h0, 1, 0);
    rd(3'd2);

    // R5: negative-over-positive write
    cur_tag = "R5";
    wr(3'd2, 32'h8000_0000);
    step(0, 0, 0, 3'd0, 32'h0, 1, 0);
    wr(3'd2, 32'h9000_0000);
    wr(3'd2, 32'h0000_0005);
    wr(3'd2, 32'h0000_0007);
    wr(3'd2, 32'h9000_0000);
    rd(3'd2);
    step(0, 0, 0, 3'd0, 32'h0, 1, 0);

    // R6: acknowledge in the same cycle as an expiry
    cur_tag = "R6";
    wr(3'd2, 32'h0);
    step(1, 0, 0, 3'd0, 32'h0, 1, 0);
    ticks(1);
    step(0, 0, 0, 3'd0, 32'h0, 1, 0);

    // R8: hypervisor decrementer on its own
    cur_tag = "R8";
    wr(3'd3, 32'h1);
    ticks(2);
    rd(3'd3); rd(3'd2);
    step(0, 0, 0, 3'd0, 32'h0, 0, 1);
    wr(3'd3, 32'hF000_0000);
    step(0, 0, 0, 3'd0, 32'h0, 0, 1);

    // R7: real-time-clock masking
    cur_tag = "R7";
    rtc_mode = 1'b1;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0);
    ticks(1);
    rd(3'd0);
    rtc_mode = 1'b0;
    rd(3'd0);

    // R9: utilisation counter load and count
    cur_tag = "R9";
    wr(3'd5, 32'hA5A5_0001);
    wr(3'd4, 32'hFFFF_FFFF);
    ticks(2);
    rd(3'd4); rd(3'd5);

    // R11: back-pressure on the response side
    cur_tag = "R11";
    rsp_ready = 1'b0;
    rd(3'd1);
    @(negedge clk); #1;
    check("R11 req_ready under stall", {63'h0, req_ready}, 64'h0);
    rd(3'd2);
    ticks(2);
    @(negedge clk); #1;
    check("R11 response held", {63'h0, rsp_valid}, 64'h1);
    rsp_ready = 1'b1;
    #1;
    check("R11 req_ready released", {63'h0, req_ready}, 64'h1);
    rd(3'd1);

    repeat (4) @(posedge clk);
    check("R11 queue drained", 64'(exp_q.size()), 64'h0);
    finish_run();
  end
endmodule